// File: doc/BRIEF.md
# PCI Power Management Control/Status Register

This block is the 16-bit power management control/status register of a PCI function, together with the wake signalling logic that hangs off it. Configuration writes arrive with two byte enables, and configuration reads return the current register image without delay. The function reports a wake condition on `wake_i`. The block records that condition in a status bit and pulls the active-low `pme_no` output low while the event is both pending and enabled.

Two parameters choose the variant. `STICKY_PME` is for functions that can wake from the cold low-power state. With it set, the status and enable bits ignore the warm reset `warm_rst_ni` and are cleared only by the cold reset `rst_ni`. `HAS_DATA_REG` tells whether the function has a Data register. With it clear, the data-select and data-scale fields are tied to zero. With it set, the data-scale field shows `data_scale_i`, which is supplied by the function's data logic.

Top module: `pm_csr`

## Requirements
- R1: After a cold reset, every stored bit is 0. The read value is therefore `data_scale_i` in bits 14:13 (0 when `HAS_DATA_REG`=0) and 0 in all other bits, and `pme_no` is 1.
- R2: A clock edge with `wake_i`=1 sets the status bit (bit 15), whatever the value of the enable bit.
- R3: Status clearing follows the write-one-to-clear rule.
  - A write with `cfg_be_i[1]`=1 and data bit 15 = 1 clears the status bit.
  - A 0 in data bit 15 leaves the status bit unchanged.
  - When `wake_i`=1 in the same cycle as a clearing write, the status bit stays set.
- R4: The enable bit (bit 8) can be read and written. `pme_no` is 0 exactly when the status bit and the enable bit are both 1.
- R5: The reserved bits 7:2 always read 0, and writes to them are ignored.
- R6: `cfg_be_i[0]` enables writes to bits 7:0 and `cfg_be_i[1]` enables writes to bits 15:8. A byte whose enable is 0 keeps its value.
- R7: The power-state field (bits 1:0) stores the value written to it. Both the warm reset and the cold reset clear it.
- R8: The data fields depend on `HAS_DATA_REG`.
  - With `HAS_DATA_REG`=1, data select (bits 12:9) can be read and written, and data scale (bits 14:13) is read-only and follows `data_scale_i`.
  - With `HAS_DATA_REG`=0, bits 14:9 read 0 and writes to them are ignored.
- R9: With `STICKY_PME`=1, a warm reset keeps the status and enable bits and clears data select and power state. A cold reset clears all of them.
- R10: With `STICKY_PME`=0, a warm reset also clears the status and enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Cold power-on reset, asynchronous, active low |
| warm_rst_ni | input | 1 | Warm reset, asynchronous, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_be_i | input | 2 | Byte enables: bit 0 for the low byte, bit 1 for the high byte |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Current register image |
| wake_i | input | 1 | Wake event from the function |
| data_scale_i | input | 2 | Scale value shown in the data-scale field |
| pme_no | output | 1 | Active-low wake request |

## Verification
The vector walk drives several input patterns, and each one tells two behaviours apart:
- Writes with only the low byte enabled, only the high byte enabled, both, or neither separate the byte-enable handling from the field storage.
- A 1 written to the status bit with its byte disabled separates a status clear from a status hold.
- Wake events with the enable bit at 0 and at 1 separate the setting of the status bit from the driving of the output.
- A clearing write in the same cycle as a wake shows which of the two wins.

A sticky instance with a Data register and a non-sticky instance without one see identical stimulus. Comparing them after a warm reset, and after a cold reset, shows which bits survive each kind of reset.

// File: rtl/pm_csr_pkg.sv
package pm_csr_pkg;
  localparam int CSR_W   = 16;
  localparam int SEL_W   = 4;
  localparam int SCALE_W = 2;
  localparam int PS_W    = 2;
  localparam int RSVD_W  = CSR_W - 1 - SCALE_W - SEL_W - 1 - PS_W;
  localparam int STS_BIT = CSR_W - 1;
  localparam int SEL_LO  = 9;
  localparam int EN_BIT  = 8;

  typedef struct packed {
    logic               sts;
    logic [SCALE_W-1:0] scale;
    logic [SEL_W-1:0]   sel;
    logic               en;
    logic [RSVD_W-1:0]  rsvd;
    logic [PS_W-1:0]    ps;
  } csr_t;
endpackage

// File: rtl/pm_wake_ctl.sv
module pm_wake_ctl #(
  parameter bit STICKY_PME = 1'b1
) (
  input  logic clk_i,
  input  logic cold_rst_ni,
  input  logic warm_rst_ni,
  input  logic wake_i,
  input  logic wr_hi_i,
  input  logic wdata_sts_i,
  input  logic wdata_en_i,
  output logic sts_o,
  output logic en_o,
  output logic pme_no
);
  logic keep_rst_n;

  generate
    if (STICKY_PME) begin : g_sticky
      assign keep_rst_n = cold_rst_ni;
    end else begin : g_plain
      assign keep_rst_n = cold_rst_ni & warm_rst_ni;
    end
  endgenerate

  // the wake event takes priority over a clearing write in the same cycle
  always_ff @(posedge clk_i or negedge keep_rst_n) begin
    if (!keep_rst_n) begin
      sts_o <= 1'b0;
      en_o  <= 1'b0;
    end else begin
      if (wake_i)                         sts_o <= 1'b1;
      else if (wr_hi_i && wdata_sts_i)    sts_o <= 1'b0;
      if (wr_hi_i)                        en_o  <= wdata_en_i;
    end
  end

  assign pme_no = ~(sts_o & en_o);
endmodule

// File: rtl/pm_field_regs.sv
module pm_field_regs
  import pm_csr_pkg::*;
#(
  parameter bit HAS_DATA_REG = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [SEL_W-1:0] wdata_sel_i,
  input  logic [PS_W-1:0]  wdata_ps_i,
  output logic [SEL_W-1:0] sel_o,
  output logic [PS_W-1:0]  ps_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ps_o <= '0;
    else if (wr_lo_i) ps_o <= wdata_ps_i;
  end

  generate
    if (HAS_DATA_REG) begin : g_sel
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      sel_o <= '0;
        else if (wr_hi_i) sel_o <= wdata_sel_i;
      end
    end else begin : g_nosel
      logic unused_sel;
      assign unused_sel = ^{wdata_sel_i, wr_hi_i};
      assign sel_o      = '0;
    end
  endgenerate
endmodule

// File: rtl/pm_rd_mux.sv
module pm_rd_mux
  import pm_csr_pkg::*;
#(
  parameter bit HAS_DATA_REG = 1'b1
) (
  input  logic               sts_i,
  input  logic               en_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [PS_W-1:0]    ps_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [CSR_W-1:0]   rdata_o
);
  csr_t img;

  always_comb begin
    img       = '0;
    img.sts   = sts_i;
    img.en    = en_i;
    img.sel   = sel_i;
    img.ps    = ps_i;
    img.scale = HAS_DATA_REG ? scale_i : '0;
  end

  assign rdata_o = img;
endmodule

// File: rtl/pm_csr.sv
module pm_csr
  import pm_csr_pkg::*;
#(
  parameter bit STICKY_PME   = 1'b1,
  parameter bit HAS_DATA_REG = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               warm_rst_ni,
  input  logic               cfg_wr_i,
  input  logic [1:0]         cfg_be_i,
  input  logic [CSR_W-1:0]   cfg_wdata_i,
  output logic [CSR_W-1:0]   cfg_rdata_o,
  input  logic               wake_i,
  input  logic [SCALE_W-1:0] data_scale_i,
  output logic               pme_no
);
  logic             any_rst_n, wr_lo, wr_hi, sts, en;
  logic [SEL_W-1:0] sel;
  logic [PS_W-1:0]  ps;
  logic             unused_wdata;

  assign any_rst_n    = rst_ni & warm_rst_ni;
  assign wr_lo        = cfg_wr_i & cfg_be_i[0];
  assign wr_hi        = cfg_wr_i & cfg_be_i[1];
  assign unused_wdata = ^{cfg_wdata_i[STS_BIT-1:SEL_LO+SEL_W], cfg_wdata_i[PS_W+RSVD_W-1:PS_W]};

  pm_wake_ctl #(.STICKY_PME(STICKY_PME)) i_wake (
    .clk_i       (clk_i),
    .cold_rst_ni (rst_ni),
    .warm_rst_ni (warm_rst_ni),
    .wake_i      (wake_i),
    .wr_hi_i     (wr_hi),
    .wdata_sts_i (cfg_wdata_i[STS_BIT]),
    .wdata_en_i  (cfg_wdata_i[EN_BIT]),
    .sts_o       (sts),
    .en_o        (en),
    .pme_no      (pme_no)
  );

  pm_field_regs #(.HAS_DATA_REG(HAS_DATA_REG)) i_fields (
    .clk_i       (clk_i),
    .rst_ni      (any_rst_n),
    .wr_lo_i     (wr_lo),
    .wr_hi_i     (wr_hi),
    .wdata_sel_i (cfg_wdata_i[SEL_LO+SEL_W-1:SEL_LO]),
    .wdata_ps_i  (cfg_wdata_i[PS_W-1:0]),
    .sel_o       (sel),
    .ps_o        (ps)
  );

  pm_rd_mux #(.HAS_DATA_REG(HAS_DATA_REG)) i_rd (
    .sts_i   (sts),
    .en_i    (en),
    .sel_i   (sel),
    .ps_i    (ps),
    .scale_i (data_scale_i),
    .rdata_o (cfg_rdata_o)
  );
endmodule

// File: rtl/pm_csr_chk.sv
module pm_csr_chk #(
  parameter bit HAS_DATA_REG = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        warm_rst_ni,
  input logic        cfg_wr_i,
  input logic [1:0]  cfg_be_i,
  input logic [15:0] cfg_wdata_i,
  input logic [15:0] cfg_rdata_o,
  input logic        wake_i,
  input logic        pme_no
);
  AST_PME_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pme_no == !(cfg_rdata_o[15] && cfg_rdata_o[8])); // R4
  AST_WAKE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni || !warm_rst_ni)
    wake_i |=> cfg_rdata_o[15]); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni || !warm_rst_ni)
    (cfg_wr_i && cfg_be_i[1] && cfg_wdata_i[15] && !wake_i) |=> !cfg_rdata_o[15]); // R3
  AST_W0_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni || !warm_rst_ni)
    (cfg_rdata_o[15] && !(cfg_wr_i && cfg_be_i[1] && cfg_wdata_i[15])) |=> cfg_rdata_o[15]); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[7:2] == 6'd0); // R5
  AST_LO_BYTE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || !warm_rst_ni)
    !(cfg_wr_i && cfg_be_i[0]) |=> $stable(cfg_rdata_o[1:0])); // R6
  AST_NODATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_DATA_REG |-> cfg_rdata_o[14:9] == 6'd0); // R8
endmodule

bind pm_csr pm_csr_chk #(.HAS_DATA_REG(HAS_DATA_REG)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .warm_rst_ni (warm_rst_ni),
  .cfg_wr_i    (cfg_wr_i),
  .cfg_be_i    (cfg_be_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .wake_i      (wake_i),
  .pme_no      (pme_no)
);

// File: tb/test_pm_csr.sv
module test_pm_csr;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        warm_rst_ni = 1'b1;
  logic        cfg_wr_i = 1'b0;
  logic [1:0]  cfg_be_i = 2'b00;
  logic [15:0] cfg_wdata_i = '0;
  logic        wake_i = 1'b0;
  logic [1:0]  data_scale_i = 2'b00;
  logic [15:0] rd_a, rd_b;
  logic        pme_a, pme_b;
  int          n_run = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  // variant A: sticky, Data register present; variant B: plain, no Data register
  pm_csr #(.STICKY_PME(1'b1), .HAS_DATA_REG(1'b1)) i_pm_csr (
    .clk_i(clk_i), .rst_ni(rst_ni), .warm_rst_ni(warm_rst_ni), .cfg_wr_i(cfg_wr_i),
    .cfg_be_i(cfg_be_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(rd_a),
    .wake_i(wake_i), .data_scale_i(data_scale_i), .pme_no(pme_a));

  pm_csr #(.STICKY_PME(1'b0), .HAS_DATA_REG(1'b0)) i_pm_csr_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .warm_rst_ni(warm_rst_ni), .cfg_wr_i(cfg_wr_i),
    .cfg_be_i(cfg_be_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(rd_b),
    .wake_i(wake_i), .data_scale_i(data_scale_i), .pme_no(pme_b));

  // {wr, be, wdata, wake, expected rdata of A, expected pme_no}; data_scale_i = 2'b10
  localparam int NV = 11;
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 2'b01, 16'hFFFF, 1'b0, 16'h4003, 1'b1}, // R5 R6 R7 low byte only
    {1'b1, 2'b10, 16'h1F00, 1'b0, 16'h5F03, 1'b1}, // R4 R8 enable and select
    {1'b0, 2'b00, 16'h0000, 1'b1, 16'hDF03, 1'b0}, // R2 R4 wake while enabled
    {1'b1, 2'b10, 16'h0000, 1'b0, 16'hC003, 1'b1}, // R3 write 0 keeps status
    {1'b1, 2'b10, 16'h0100, 1'b0, 16'hC103, 1'b0}, // R4 re-enable
    {1'b1, 2'b01, 16'h8001, 1'b0, 16'hC101, 1'b0}, // R6 bit 15 with high byte off
    {1'b1, 2'b10, 16'h8100, 1'b0, 16'h4101, 1'b1}, // R3 clear status
    {1'b1, 2'b10, 16'h8100, 1'b1, 16'hC101, 1'b0}, // R3 wake beats clear
    {1'b1, 2'b11, 16'h8302, 1'b0, 16'h4302, 1'b1}, // R6 R7 R8 both bytes
    {1'b1, 2'b00, 16'hFFFF, 1'b0, 16'h4302, 1'b1}, // R6 no byte enabled
    {1'b1, 2'b10, 16'h0000, 1'b1, 16'hC002, 1'b1}  // R2 status set with enable off
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic wr, input logic [1:0] be, input logic [15:0] wd, input logic wk);
    cfg_wr_i = wr; cfg_be_i = be; cfg_wdata_i = wd; wake_i = wk;
    @(negedge clk_i);
    cfg_wr_i = 1'b0; cfg_be_i = 2'b00; cfg_wdata_i = '0; wake_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 A rdata", rd_a, 16'h0000);
    check("R1 B rdata", rd_b, 16'h0000);
    check("R1 pme_no", {14'd0, pme_a, pme_b}, 16'h0003);

    data_scale_i = 2'b10;
    #1;
    check("R8 A scale", rd_a, 16'h4000);
    check("R8 B scale", rd_b, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i][36], VEC[i][35:34], VEC[i][33:18], VEC[i][17]);
      check($sformatf("R2 R3 R4 R6 R7 R8 vec%0d A", i), rd_a, VEC[i][16:1]);
      check($sformatf("R5 R8 vec%0d B", i), rd_b, VEC[i][16:1] & 16'h81FF);
      check($sformatf("R4 vec%0d pme_no", i), {14'd0, pme_a, pme_b}, {14'd0, VEC[i][0], VEC[i][0]});
    end

    // status 1, enable 0, ps 2 -> enable
    cycle(1'b1, 2'b10, 16'h0100, 1'b0);
    check("R4 A enabled pending", rd_a, 16'hC102);
    check("R4 pme low", {14'd0, pme_a, pme_b}, 16'h0000);

    // warm reset
    warm_rst_ni = 1'b0;
    @(negedge clk_i);
    warm_rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 A warm keeps sticky", rd_a, 16'hC100);
    check("R10 B warm clears", rd_b, 16'h0000);
    check("R9 R10 pme_no", {14'd0, pme_a, pme_b}, 16'h0001);

    data_scale_i = 2'b01;
    #1;
    check("R8 A scale follows", rd_a, 16'hA100);

    // cold reset
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 A cold clears", rd_a, 16'h2000);
    check("R1 B cold", rd_b, 16'h0000);
    check("R1 pme_no cold", {14'd0, pme_a, pme_b}, 16'h0003);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule